// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block runs one pass of analog-to-digital conversions over a contiguous group of input channels. The group always starts at channel 0 and ends at a last channel chosen in the control register. A pass can be started in three ways: a software write to the start bit, a pulse on the timer trigger input, or a pulse on the external trigger input. For each channel, the block asks an external converter for a sample using a one-cycle start pulse, then waits for a done strobe. When the strobe arrives, it stores the returned sample in that channel's own data register.

When the final channel has been stored, the block sets a completion flag, clears its busy/start bit and returns to idle. If interrupts are enabled, an interrupt request is raised at the same time. If software clears the start bit while a pass is running, the pass stops at once and the completion flag is not set. The completion flag can only be cleared by a read followed by a write.

A small register port gives access to the block. Address 0 is the control/status word. Addresses 1 to NUM_CH hold the channel results, so channel c is at address 1+c. The analog converter itself sits outside this block.

Top module: `adc_scan_seq`

## Requirements
- R1: A write to address 0 with bit 0 (start) = 1 and mode field bits [7:6] = 2'b10 starts a pass while idle. The last-channel field bits [5:3] and mode from the same write are used for that pass. Reading address 0 returns: bit 0 busy, bit 1 interrupt enable, bit 2 completion flag, bits [5:3] last channel, bits [7:6] mode. After reset, all of these read as 0.
- R2: A one-cycle pulse on timer_trig_i or ext_trig_i starts a pass while idle, provided the stored mode is 2'b10. The pass uses the stored last-channel field.
- R3: A pass issues exactly one conversion (a conv_start_o pulse with conv_ch_o) for each channel from 0 up to the last channel, in ascending order. Channels above the last one are neither converted nor written.
- R4: When conv_done_i arrives for channel c, conv_data_i is stored and reads back at address 1+c in the low DATA_W bits. This happens before the next channel is issued.
- R5: After the last channel's result is stored, the completion flag (bit 2) becomes 1 and busy (bit 0) becomes 0 in the same cycle.
- R6: irq_o is 1 exactly while the completion flag and the interrupt enable (bit 1) are both 1.
- R7: Writing address 0 with bit 0 = 0 during a pass aborts it. No further conversion is issued, and results still outstanding are not stored. The completion flag is not set.
- R8: The completion flag is cleared by a write to address 0 with bit 2 = 0, but only after a read of address 0 (reg_re_i) that saw the flag at 1. Without that earlier read, the write leaves the flag at 1. Software can never set the flag.
- R9: A pass started after an abort begins again at channel 0.
- R10: While a pass is running, triggers and start writes are ignored. Changes to the last-channel field written during a pass take effect only from the next pass.
- R11: If the mode field is not 2'b10, neither a start write nor a trigger begins a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (arms completion-flag clear) |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data, combinational from address |
| timer_trig_i | input | 1 | Timer start trigger pulse |
| ext_trig_i | input | 1 | External start trigger pulse |
| conv_start_o | output | 1 | One-cycle request to the converter |
| conv_ch_o | output | CH_W | Channel of the current conversion |
| conv_done_i | input | 1 | Converter result strobe |
| conv_data_i | input | DATA_W | Converter result |
| irq_o | output | 1 | Pass-complete interrupt request |

## Verification
The assertions assume that the converter answers each start pulse with at most one done strobe. They also assume that conv_done_i is never asserted while no conversion is outstanding in the current pass. The bench's converter model meets both assumptions. It replies to each start a fixed three cycles later. After an abort, the bench waits well past any late reply before starting a new pass, so a stale strobe can only land while the block is idle. Trigger inputs and register strobes are driven one cycle at a time, away from the sampling edge.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int unsigned BIT_START = 0;
  localparam int unsigned BIT_IE    = 1;
  localparam int unsigned BIT_DONE  = 2;
  localparam int unsigned BIT_LAST  = 3;

  localparam logic [1:0] MODE_MULTI = 2'b10;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/scan_regs.sv
module scan_regs
  import adc_scan_pkg::*;
#(
  parameter int unsigned CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic            ie_wr_i,
  input  logic            done_wr_i,
  input  logic [CH_W-1:0] last_wr_i,
  input  logic [1:0]      mode_wr_i,
  input  logic            pass_end_i,
  output logic            ie_o,
  output logic            done_o,
  output logic [CH_W-1:0] last_o,
  output logic [1:0]      mode_o,
  output logic            irq_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o    <= 1'b0;
      done_o  <= 1'b0;
      last_o  <= '0;
      mode_o  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        ie_o   <= ie_wr_i;
        last_o <= last_wr_i;
        mode_o <= mode_wr_i;
      end
      // completion wins over a simultaneous clear
      if (pass_end_i) begin
        done_o  <= 1'b1;
        armed_q <= 1'b0;
      end else if (wr_en_i && armed_q && !done_wr_i) begin
        done_o  <= 1'b0;
        armed_q <= 1'b0;
      end else if (rd_en_i && done_o) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign irq_o = done_o & ie_o;

  assert_done_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(pass_end_i));

  assert_done_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(wr_en_i) && $past(armed_q));
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            abort_i,
  input  logic [CH_W-1:0] last_i,
  input  logic            conv_done_i,
  output logic            busy_o,
  output logic [CH_W-1:0] ch_o,
  output logic            conv_start_o,
  output logic            wr_res_o,
  output logic            pass_end_o
);
  scan_state_e     state_q;
  logic [CH_W-1:0] ch_q;
  logic [CH_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ch_q    <= '0;
      last_q  <= '0;
    end else if (abort_i) begin
      state_q <= S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_ISSUE;
          ch_q    <= '0;
          last_q  <= last_i;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (conv_done_i) begin
          if (ch_q == last_q) begin
            state_q <= S_IDLE;
          end else begin
            ch_q    <= ch_q + 1'b1;
            state_q <= S_ISSUE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign ch_o         = ch_q;
  assign conv_start_o = (state_q == S_ISSUE);
  assign wr_res_o     = (state_q == S_WAIT) && conv_done_i && !abort_i;
  assign pass_end_o   = wr_res_o && (ch_q == last_q);

  assert_first_ch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ch_q == '0);

  assert_ch_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ISSUE && $past(state_q) == S_WAIT) |-> ch_q == CH_W'($past(ch_q) + 1'b1));

  assert_ch_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ch_q <= last_q);

  assert_one_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  assert_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_o && !conv_start_o);
endmodule

// File: rtl/scan_result_bank.sv
module scan_result_bank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 10,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] res_q [NUM_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CH; i++) res_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NUM_CH; i++)
        if (wr_ch_i == CH_W'(i)) res_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = res_q[rd_ch_i];

  assert_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> res_q[$past(wr_ch_i)] == $past(wr_data_i));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned MODE_LSB = BIT_LAST + CH_W,
  localparam int unsigned CTRL_W = MODE_LSB + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              timer_trig_i,
  input  logic              ext_trig_i,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_ch_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              irq_o
);
  logic            ctrl_sel, ctrl_wr, ctrl_rd;
  logic            busy, done, ie;
  logic [CH_W-1:0] last_q, last_sel, wr_last;
  logic [1:0]      mode_q, wr_mode;
  logic            sw_start, hw_start, start, abort;
  logic            wr_res, pass_end;
  logic [DATA_W-1:0] res_rd;
  logic [CH_W-1:0] rd_ch;
  logic            unused_wdata;

  assign ctrl_sel = (reg_addr_i == '0);
  assign ctrl_wr  = reg_we_i && ctrl_sel;
  assign ctrl_rd  = reg_re_i && ctrl_sel;
  assign wr_last  = reg_wdata_i[BIT_LAST +: CH_W];
  assign wr_mode  = reg_wdata_i[MODE_LSB +: 2];

  assign sw_start = ctrl_wr && reg_wdata_i[BIT_START] && (wr_mode == MODE_MULTI) && !busy;
  assign hw_start = (timer_trig_i || ext_trig_i) && !ctrl_wr && (mode_q == MODE_MULTI) && !busy;
  assign start    = sw_start || hw_start;
  assign last_sel = sw_start ? wr_last : last_q;
  assign abort    = ctrl_wr && !reg_wdata_i[BIT_START] && busy;
  assign unused_wdata = ^reg_wdata_i[REG_W-1:CTRL_W];

  scan_regs #(.CH_W(CH_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (ctrl_wr),
    .rd_en_i    (ctrl_rd),
    .ie_wr_i    (reg_wdata_i[BIT_IE]),
    .done_wr_i  (reg_wdata_i[BIT_DONE]),
    .last_wr_i  (wr_last),
    .mode_wr_i  (wr_mode),
    .pass_end_i (pass_end),
    .ie_o       (ie),
    .done_o     (done),
    .last_o     (last_q),
    .mode_o     (mode_q),
    .irq_o      (irq_o)
  );

  scan_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .abort_i      (abort),
    .last_i       (last_sel),
    .conv_done_i  (conv_done_i),
    .busy_o       (busy),
    .ch_o         (conv_ch_o),
    .conv_start_o (conv_start_o),
    .wr_res_o     (wr_res),
    .pass_end_o   (pass_end)
  );

  assign rd_ch = CH_W'(reg_addr_i - 1'b1);

  scan_result_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_res),
    .wr_ch_i   (conv_ch_o),
    .wr_data_i (conv_data_i),
    .rd_ch_i   (rd_ch),
    .rd_data_o (res_rd)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (ctrl_sel) begin
      reg_rdata_o[BIT_START]         = busy;
      reg_rdata_o[BIT_IE]            = ie;
      reg_rdata_o[BIT_DONE]          = done;
      reg_rdata_o[BIT_LAST +: CH_W]  = last_q;
      reg_rdata_o[MODE_LSB +: 2]     = mode_q;
    end else if (reg_addr_i <= ADDR_W'(NUM_CH)) begin
      reg_rdata_o[DATA_W-1:0] = res_rd;
    end
  end

  assert_end_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> $fell(busy));

  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy);

  assert_mode_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(mode_q) == MODE_MULTI || $past(wr_mode) == MODE_MULTI);
endmodule

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
  localparam int NUM_CH = 8;
  localparam int DATA_W = 10;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int CH_W   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic timer_trig = 1'b0, ext_trig = 1'b0;
  logic conv_start;
  logic [CH_W-1:0] conv_ch;
  logic conv_done = 1'b0;
  logic [DATA_W-1:0] conv_data = '0;
  logic irq;

  int n_chk = 0, n_bad = 0, pops = 0;
  int seed = 0;
  int exp_q[$];
  int lat_cnt = 0;
  int ch_cap = 0;

  always #10 clk = ~clk;

  adc_scan_seq #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .timer_trig_i(timer_trig), .ext_trig_i(ext_trig),
    .conv_start_o(conv_start), .conv_ch_o(conv_ch),
    .conv_done_i(conv_done), .conv_data_i(conv_data),
    .irq_o(irq)
  );

  function automatic int mdl(int ch, int s);
    return (ch * 73 + s) % 1024;
  endfunction

  function automatic logic [REG_W-1:0] cw(bit st, bit ie, int last, logic [1:0] mode);
    logic [REG_W-1:0] w;
    w = '0;
    w[0] = st; w[1] = ie; w[5:3] = last[2:0]; w[7:6] = mode;
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model: replies three cycles after each start
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        conv_done = 1'b1;
        conv_data = DATA_W'(mdl(ch_cap, seed));
      end
    end
    if (rst_n && conv_start) begin
      ch_cap  = int'(conv_ch);
      lat_cnt = 3;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      pops++;
      if (exp_q.size() == 0) chk("R3 unexpected conversion", int'(conv_ch), -1);
      else chk("R3 channel order", int'(conv_ch), exp_q.pop_front());
    end
  end

  task automatic reg_write(int addr, logic [REG_W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ADDR_W'(addr); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic reg_read(int addr);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = ADDR_W'(addr);
    @(negedge clk);
    reg_re = 1'b0; reg_addr = '0;
  endtask

  task automatic peek(int addr, output int v);
    reg_addr = ADDR_W'(addr);
    #1;
    v = int'(reg_rdata);
    reg_addr = '0;
  endtask

  task automatic push_pass(int last);
    for (int c = 0; c <= last; c++) exp_q.push_back(c);
  endtask

  task automatic wait_idle();
    int v;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #2;
      peek(0, v);
      if (v[0] == 0) break;
    end
  endtask

  task automatic pulse(bit which_ext);
    @(negedge clk);
    if (which_ext) ext_trig = 1'b1; else timer_trig = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0; timer_trig = 1'b0;
  endtask

  initial begin
    int v, timer_seed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;

    peek(0, v); chk("R1 reset status", v, 0);
    chk("R6 reset irq", int'(irq), 0);
    chk("R3 reset conv_start", int'(conv_start), 0);

    // software pass, channels 0..2, irq enabled
    seed = 100; push_pass(2);
    reg_write(0, cw(1, 1, 2, 2'b10));
    #2; peek(0, v); chk("R1 busy after start", v & 1, 1);
    wait_idle();
    chk("R3 queue drained", exp_q.size(), 0);
    peek(0, v); chk("R5 done set busy clear", v & 5, 4);
    chk("R6 irq high", int'(irq), 1);
    for (int c = 0; c <= 2; c++) begin peek(1 + c, v); chk("R4 result", v, mdl(c, 100)); end
    peek(4, v); chk("R3 channel above last untouched", v, 0);

    // clear without read: no effect
    reg_write(0, cw(0, 1, 2, 2'b10));
    #2; peek(0, v); chk("R8 write0 without read keeps flag", (v >> 2) & 1, 1);
    chk("R6 irq still high", int'(irq), 1);
    reg_read(0);
    reg_write(0, cw(0, 1, 2, 2'b10));
    #2; peek(0, v); chk("R8 read then write0 clears", (v >> 2) & 1, 0);
    chk("R6 irq drops with flag", int'(irq), 0);

    // timer pass over all channels, with mid-pass writes and trigger
    reg_write(0, cw(0, 1, 7, 2'b10));
    seed = 200; timer_seed = 200; push_pass(7);
    pulse(0);
    repeat (6) @(negedge clk);
    reg_write(0, cw(1, 0, 1, 2'b10));
    pulse(1);
    wait_idle();
    chk("R10 full pass unaffected", exp_q.size(), 0);
    peek(8, v); chk("R2 timer pass last channel", v, mdl(7, 200));
    peek(0, v); chk("R5 done after timer pass", (v >> 2) & 1, 1);
    chk("R6 irq off with enable 0", int'(irq), 0);
    reg_write(0, cw(0, 1, 1, 2'b10));
    #2; chk("R6 irq on when enable set", int'(irq), 1);
    reg_read(0);
    reg_write(0, cw(0, 0, 1, 2'b10));

    // external trigger uses last field written mid-pass (1)
    seed = 300; push_pass(1);
    pulse(1);
    wait_idle();
    chk("R10 new last applies next pass", exp_q.size(), 0);
    peek(2, v); chk("R2 ext pass ch1", v, mdl(1, 300));
    peek(3, v); chk("R10 ch2 kept from timer pass", v, mdl(2, timer_seed));
    reg_read(0);
    reg_write(0, cw(0, 0, 5, 2'b10));

    // abort after channel 1 issued
    seed = 400; push_pass(5);
    begin
      int base;
      base = pops;
      reg_write(0, cw(1, 0, 5, 2'b10));
      wait (pops >= base + 2);
      reg_write(0, cw(0, 0, 5, 2'b10));
      exp_q.delete();
    end
    repeat (20) @(negedge clk); #2;
    peek(0, v); chk("R7 abort idle no done", v & 5, 0);
    peek(1, v); chk("R7 ch0 stored before abort", v, mdl(0, 400));
    peek(2, v); chk("R7 ch1 not stored", v, mdl(1, 300));
    peek(6, v); chk("R7 ch5 untouched", v, mdl(5, timer_seed));

    // restart from channel 0
    seed = 500; push_pass(3);
    reg_write(0, cw(1, 0, 3, 2'b10));
    wait_idle();
    chk("R9 restart full group", exp_q.size(), 0);
    peek(1, v); chk("R9 ch0 new value", v, mdl(0, 500));
    peek(4, v); chk("R9 ch3 new value", v, mdl(3, 500));
    reg_read(0);
    reg_write(0, cw(0, 0, 3, 2'b10));

    // wrong mode: write start and triggers ignored
    reg_write(0, cw(1, 0, 3, 2'b01));
    pulse(0); pulse(1);
    repeat (10) @(negedge clk); #2;
    peek(0, v); chk("R11 no pass in other mode", v & 5, 0);
    peek(1, v); chk("R11 results unchanged", v, mdl(0, 500));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule